// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the control state machine for one thread of a register-rename pipeline stage. Each cycle it decides whether the stage renames an instruction, blocks, drains its skid buffer, squashes, or waits for a serializing instruction. It receives squash requests from commit, block and unblock requests from the later stages, a resource-full indication, a reorder-buffer-empty flag and the count of instructions that have been renamed but not yet dispatched. It sends block and unblock pulses back to decode. It holds a small FIFO of instruction tags, the skid buffer, that absorbs instructions arriving while the stage cannot rename them. Operand lookup and the map tables belong to neighbouring logic.

The data path is one instruction wide. The input stream has a valid but no ready. Decode cannot be held off within a cycle, so every instruction the stage cannot rename goes into the skid buffer, and back-pressure reaches decode only through the `up_block`/`up_unblock` pulses. The buffer depth is sized so that instructions still in flight from decode after a block pulse will fit. The output stream also has a valid but no ready: `out_valid` is the rename-enable for the current cycle, and the later stages apply back-pressure through `be_block`/`be_unblock`.

A serialize-before instruction waits in the block until the reorder buffer is empty and nothing is in flight. It is then released ahead of everything buffered behind it. A serialize-after instruction forces the instruction that follows it to wait in the same way.

Top module: `rename_stall_ctl`

## Requirements
- R1: After reset the state is Idle. The `state` output uses this encoding: Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4, SerializeStall=5. After reset no pulse, output or error is asserted. `up_block` and `up_unblock` are never asserted in the same cycle.
- R2: A squash input has the highest priority, and a squash-busy input comes second. Either one moves the state to Squashing at the next edge. The input instruction of that cycle is discarded and no instruction is renamed.
- R3: A stall is present in a cycle when (the held block flag OR `be_block`) AND NOT `be_unblock` is true, or when `res_full` is high. The held block flag is set by `be_block` and cleared by `be_unblock`, and `be_unblock` wins if both are high. During a stall the valid input is pushed to the back of the skid buffer. `up_block` pulses only if the state is neither Blocked nor Unblocking. The state becomes Blocked unless it is SerializeStall.
- R4: In a cycle with no squash, no squash-busy and no stall, Blocked moves to Unblocking and Squashing moves to Running. In the same cycle the stage renames as it would in the new state.
- R5: While Unblocking, the stage renames from the head of the skid buffer and appends each valid input to its back. In the cycle the buffer becomes empty, `up_unblock` pulses and the state becomes Running.
- R6: A squash while Blocked, Unblocking or SerializeStall pulses `up_unblock`. In every state a squash empties the skid buffer and drops any held serializing instruction, so none of them is ever emitted.
- R7: An unhandled serialize-before instruction is not emitted. It is held, and the state becomes SerializeStall, with an `up_block` pulse under the rule of R3. The state stays SerializeStall while `rob_empty` is low or `inflight` is nonzero. Nothing is emitted in that state, and valid inputs go to the skid buffer.
- R8: When the stall ends (`rob_empty` high and `inflight` zero, with no squash or stall), the held instruction is marked handled and pushed to the front of the skid buffer, and the state becomes Unblocking. The held instruction is therefore emitted before every instruction buffered behind it.
- R9: When an unhandled serialize-after instruction is emitted, the next instruction becomes serialize-before. If that next instruction is already in the skid buffer, its entry is marked. Otherwise a sticky flag marks the next instruction to arrive. The flag is dropped without effect if `rob_empty` is high and `inflight` is zero when that instruction is renamed.
- R10: The skid buffer holds 2 × BE_DELAY × DEC_W + REN_W entries, which is 5 by default. A push into a full buffer is dropped and sets `skid_err`, which stays set until reset.
- R11: `stage_active` is high exactly when the state is Unblocking.
- R12: In Idle or Running, with no squash, squash-busy or stall, a valid input that is not serialize-before is emitted in the same cycle: `out_valid` is high and `out_tag` equals `in_tag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction from decode present |
| in_tag | input | TAG_W | Instruction tag |
| in_sbefore | input | 1 | Instruction is serialize-before |
| in_safter | input | 1 | Instruction is serialize-after |
| cm_squash | input | 1 | Squash request from commit |
| cm_sq_busy | input | 1 | Commit still squashing the reorder buffer |
| be_block | input | 1 | Later stage requests a block |
| be_unblock | input | 1 | Later stage releases its block |
| res_full | input | 1 | Back-end queues full this cycle |
| rob_empty | input | 1 | Reorder buffer empty |
| inflight | input | CNT_W | Renamed instructions not yet dispatched |
| out_valid | output | 1 | Rename enable: an instruction is renamed this cycle |
| out_tag | output | TAG_W | Tag of the renamed instruction |
| up_block | output | 1 | Block pulse to decode |
| up_unblock | output | 1 | Unblock pulse to decode |
| skid_push | output | 1 | Skid buffer write (front or back) this cycle |
| skid_pop | output | 1 | Skid buffer head consumed this cycle |
| stage_active | output | 1 | Stage is draining its skid buffer |
| state | output | 3 | Current state, encoded as in R1 |
| skid_err | output | 1 | Sticky skid buffer overflow |

## Verification
Several functions can fall in the same cycle. Leaving Blocked coincides with renaming the skid head, with an append of the new input, and in some cycles with completing the drain and pulsing unblock. Emitting a serialize-after instruction from the skid buffer coincides with marking the entry behind it. The bench provokes these cases by releasing `be_block` in the same cycle as a new input, and by stacking a serialize-after instruction and its successor in the buffer before the release. A per-cycle reference model built on queues predicts the state, every pulse and every emitted tag, and directed checks confirm the order in which tags emerge.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_BLK  = 3'd2,
    ST_UNB  = 3'd3,
    ST_SQ   = 3'd4,
    ST_SER  = 3'd5
  } rn_state_e;

  typedef struct packed {
    logic done;   // serialize already handled
    logic sbef;   // serialize-before
    logic saft;   // serialize-after
  } rn_flags_t;
endpackage

// File: rtl/rn_skid.sv
module rn_skid
  import rn_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int TAG_W = 6,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             pop,
  input  logic             mark,
  input  logic             pf_v,
  input  logic [TAG_W-1:0] pf_tag,
  input  rn_flags_t        pf_fl,
  input  logic             pb_v,
  input  logic [TAG_W-1:0] pb_tag,
  input  rn_flags_t        pb_fl,
  output logic [TAG_W-1:0] head_tag,
  output rn_flags_t        head_fl,
  output logic [CW-1:0]    cnt,
  output logic             ovf
);
  logic [TAG_W-1:0] tg_q [DEPTH];
  rn_flags_t        fl_q [DEPTH];
  logic [PW-1:0]    rd_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic [PW-1:0] idx(input int a, input int b);
    int s;
    s = a + b;
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  logic [PW-1:0] sec_pos, back_pos, front_pos;
  logic [CW-1:0] base_cnt, after_f;
  logic          front_ok, back_ok;

  always_comb begin
    sec_pos   = idx(int'(rd_q), 1);
    back_pos  = idx(int'(rd_q), int'(cnt_q));
    front_pos = (rd_q == '0) ? PW'(DEPTH - 1) : rd_q - PW'(1);
    base_cnt  = cnt_q - CW'(pop);
    front_ok  = pf_v && (base_cnt < CW'(DEPTH));
    after_f   = base_cnt + CW'(front_ok);
    back_ok   = pb_v && (after_f < CW'(DEPTH));
    ovf       = !clr && ((pf_v && !front_ok) || (pb_v && !back_ok));
  end

  assign head_tag = tg_q[rd_q];
  assign head_fl  = fl_q[rd_q];
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (front_ok) begin
        rd_q             <= front_pos;
        tg_q[front_pos]  <= pf_tag;
        fl_q[front_pos]  <= pf_fl;
      end else if (pop) begin
        rd_q <= sec_pos;
      end
      if (back_ok) begin
        tg_q[back_pos] <= pb_tag;
        fl_q[back_pos] <= pb_fl;
      end
      if (mark) fl_q[sec_pos].sbef <= 1'b1;
      cnt_q <= after_f + CW'(back_ok);
    end
  end
endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int TAG_W = 6,
  parameter int CNT_W = 4,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_sbefore,
  input  logic             in_safter,
  input  logic             cm_squash,
  input  logic             cm_sq_busy,
  input  logic             be_block,
  input  logic             be_unblock,
  input  logic             res_full,
  input  logic             rob_empty,
  input  logic [CNT_W-1:0] inflight,
  input  logic [CW-1:0]    skid_cnt,
  input  logic [TAG_W-1:0] head_tag,
  input  rn_flags_t        head_fl,
  output logic             clr,
  output logic             pop,
  output logic             mark,
  output logic             pf_v,
  output logic [TAG_W-1:0] pf_tag,
  output rn_flags_t        pf_fl,
  output logic             pb_v,
  output logic [TAG_W-1:0] pb_tag,
  output rn_flags_t        pb_fl,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             up_block,
  output logic             up_unblock,
  output rn_state_e        st
);
  rn_state_e        st_q, st_n;
  logic             stall_q, stall_n, stall_now;
  logic             sticky_q, sticky_n;
  logic             hold_v_q, hold_v_n;
  logic [TAG_W-1:0] hold_tag_q, hold_tag_n;
  logic             quiet;

  assign st     = st_q;
  assign quiet  = rob_empty && (inflight == '0);
  assign pf_tag = hold_tag_q;
  assign pf_fl  = '{done: 1'b1, sbef: 1'b0, saft: 1'b0};
  assign pb_tag = in_tag;
  assign pb_fl  = '{done: 1'b0, sbef: in_sbefore, saft: in_safter};

  always_comb begin
    logic             ren, unb, have;
    logic [TAG_W-1:0] cur_tag;
    rn_flags_t        cur_fl;
    st_n       = st_q;
    stall_n    = (stall_q | be_block) & ~be_unblock;
    stall_now  = stall_n | res_full;
    sticky_n   = sticky_q;
    hold_v_n   = hold_v_q;
    hold_tag_n = hold_tag_q;
    clr = 1'b0; pop = 1'b0; mark = 1'b0; pf_v = 1'b0; pb_v = 1'b0;
    out_valid = 1'b0; out_tag = '0; up_block = 1'b0; up_unblock = 1'b0;
    ren = 1'b0; unb = 1'b0; have = 1'b0; cur_tag = '0; cur_fl = '0;

    if (cm_squash) begin
      if (st_q == ST_BLK || st_q == ST_UNB || st_q == ST_SER) up_unblock = 1'b1;
      hold_v_n = 1'b0;
      clr      = 1'b1;
      st_n     = ST_SQ;
    end else if (cm_sq_busy) begin
      st_n = ST_SQ;
    end else if (stall_now) begin
      pb_v = in_valid;
      if (st_q != ST_BLK && st_q != ST_UNB) up_block = 1'b1;
      if (st_q != ST_SER) st_n = ST_BLK;
    end else begin
      unique case (st_q)
        ST_BLK: begin st_n = ST_UNB; ren = 1'b1; end
        ST_SQ:  begin st_n = ST_RUN; ren = 1'b1; end
        ST_SER: begin
          pb_v = in_valid;
          if (quiet) begin
            pf_v     = 1'b1;
            hold_v_n = 1'b0;
            st_n     = ST_UNB;
          end
        end
        default: ren = 1'b1;
      endcase
    end

    if (ren) begin
      unb = (st_n == ST_UNB);
      if (unb) begin
        pb_v    = in_valid;
        have    = (skid_cnt != '0);
        cur_tag = head_tag;
        cur_fl  = head_fl;
      end else begin
        have    = in_valid;
        cur_tag = in_tag;
        cur_fl  = '{done: 1'b0, sbef: in_sbefore, saft: in_safter};
      end
      if (have) begin
        pop = unb;
        if (sticky_q) begin
          sticky_n = 1'b0;
          if (!quiet) cur_fl.sbef = 1'b1;
        end
        if (cur_fl.sbef && !cur_fl.done) begin
          hold_v_n   = 1'b1;
          hold_tag_n = cur_tag;
          st_n       = ST_SER;
          if (st_q != ST_BLK && st_q != ST_UNB) up_block = 1'b1;
        end else begin
          out_valid = 1'b1;
          out_tag   = cur_tag;
          if (cur_fl.saft && !cur_fl.done) begin
            if (unb && skid_cnt > CW'(1)) mark = 1'b1;
            else sticky_n = 1'b1;
          end
        end
      end
      if (unb && st_n == ST_UNB && skid_cnt == CW'(pop) && !pb_v) begin
        up_unblock = 1'b1;
        st_n       = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      stall_q    <= 1'b0;
      sticky_q   <= 1'b0;
      hold_v_q   <= 1'b0;
      hold_tag_q <= '0;
    end else begin
      st_q       <= st_n;
      stall_q    <= stall_n;
      sticky_q   <= sticky_n;
      hold_v_q   <= hold_v_n;
      hold_tag_q <= hold_tag_n;
    end
  end
endmodule

// File: rtl/rename_stall_ctl.sv
module rename_stall_ctl
  import rn_pkg::*;
#(
  parameter int TAG_W    = 6,
  parameter int CNT_W    = 4,
  parameter int BE_DELAY = 2,
  parameter int DEC_W    = 1,
  parameter int REN_W    = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_sbefore,
  input  logic             in_safter,
  input  logic             cm_squash,
  input  logic             cm_sq_busy,
  input  logic             be_block,
  input  logic             be_unblock,
  input  logic             res_full,
  input  logic             rob_empty,
  input  logic [CNT_W-1:0] inflight,
  output logic             out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic             up_block,
  output logic             up_unblock,
  output logic             skid_push,
  output logic             skid_pop,
  output logic             stage_active,
  output logic [2:0]       state,
  output logic             skid_err
);
  localparam int DEPTH = 2 * BE_DELAY * DEC_W + REN_W;
  localparam int CW    = $clog2(DEPTH + 1);

  logic             clr, pop, mark, pf_v, pb_v, ovf, err_q;
  logic [TAG_W-1:0] pf_tag, pb_tag, head_tag;
  rn_flags_t        pf_fl, pb_fl, head_fl;
  logic [CW-1:0]    skid_cnt;
  rn_state_e        st;

  rn_skid #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_skid (
    .clk(clk), .rst_n(rst_n), .clr(clr), .pop(pop), .mark(mark),
    .pf_v(pf_v), .pf_tag(pf_tag), .pf_fl(pf_fl),
    .pb_v(pb_v), .pb_tag(pb_tag), .pb_fl(pb_fl),
    .head_tag(head_tag), .head_fl(head_fl), .cnt(skid_cnt), .ovf(ovf)
  );

  rn_ctrl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .in_sbefore(in_sbefore), .in_safter(in_safter),
    .cm_squash(cm_squash), .cm_sq_busy(cm_sq_busy),
    .be_block(be_block), .be_unblock(be_unblock), .res_full(res_full),
    .rob_empty(rob_empty), .inflight(inflight),
    .skid_cnt(skid_cnt), .head_tag(head_tag), .head_fl(head_fl),
    .clr(clr), .pop(pop), .mark(mark),
    .pf_v(pf_v), .pf_tag(pf_tag), .pf_fl(pf_fl),
    .pb_v(pb_v), .pb_tag(pb_tag), .pb_fl(pb_fl),
    .out_valid(out_valid), .out_tag(out_tag),
    .up_block(up_block), .up_unblock(up_unblock), .st(st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | ovf;
  end

  assign skid_push    = pf_v | pb_v;
  assign skid_pop     = pop;
  assign stage_active = (st == ST_UNB);
  assign state        = st;
  assign skid_err     = err_q;
endmodule

// File: rtl/rn_chk.sv
module rn_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cm_squash,
  input logic             cm_sq_busy,
  input logic             rob_empty,
  input logic [CNT_W-1:0] inflight,
  input logic             out_valid,
  input logic             up_block,
  input logic             up_unblock,
  input logic [2:0]       state
);
  // R2
  squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_squash |=> (state == 3'd4));

  // R6
  squash_unblk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_squash && (state == 3'd2 || state == 3'd3 || state == 3'd5)) |-> up_unblock);

  // R3
  block_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2 || state == 3'd3) |-> !up_block);

  // R5
  done_unblk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_unblock && !cm_squash) |=> (state == 3'd1));

  // R7
  ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5 && !cm_squash && !cm_sq_busy && !(rob_empty && inflight == '0))
      |=> (state == 3'd5));

  // R7
  ser_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd5) |-> !out_valid);

  // R1
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_block && up_unblock));
endmodule

bind rename_stall_ctl rn_chk #(.CNT_W(CNT_W)) u_rn_chk (
  .clk(clk), .rst_n(rst_n), .cm_squash(cm_squash), .cm_sq_busy(cm_sq_busy),
  .rob_empty(rob_empty), .inflight(inflight), .out_valid(out_valid),
  .up_block(up_block), .up_unblock(up_unblock), .state(state)
);

// File: tb/test_rename_stall_ctl.sv
`timescale 1ns/1ps
module test_rename_stall_ctl;
  localparam int DEPTH = 5;
  localparam int S_IDLE = 0, S_RUN = 1, S_BLK = 2, S_UNB = 3, S_SQ = 4, S_SER = 5;

  logic clk = 0, rst_n = 0;
  logic i_v = 0, i_sb = 0, i_sa = 0, sq = 0, sqb = 0, bb = 0, bu = 0, rf = 0, re = 1;
  logic [5:0] i_tag = 0;
  logic [3:0] infl = 0;
  logic out_valid, up_block, up_unblock, skid_push, skid_pop, stage_active, skid_err;
  logic [5:0] out_tag;
  logic [2:0] state;

  always #4 clk = ~clk;

  rename_stall_ctl i_rename_stall_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(i_v), .in_tag(i_tag), .in_sbefore(i_sb),
    .in_safter(i_sa), .cm_squash(sq), .cm_sq_busy(sqb), .be_block(bb),
    .be_unblock(bu), .res_full(rf), .rob_empty(re), .inflight(infl),
    .out_valid(out_valid), .out_tag(out_tag), .up_block(up_block),
    .up_unblock(up_unblock), .skid_push(skid_push), .skid_pop(skid_pop),
    .stage_active(stage_active), .state(state), .skid_err(skid_err)
  );

  int total = 0, fails = 0;
  bit done = 0;
  int got[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pos(input int t);
    foreach (got[k]) if (got[k] == t) return k;
    return -1;
  endfunction

  // reference model state: entries are {done, sbef, saft, tag[5:0]}
  int m_st = S_IDLE;
  bit [8:0] mq[$];
  bit m_stall = 0, m_sticky = 0, m_hv = 0, m_err = 0;
  bit [8:0] m_hold = 0;
  int n_st;
  bit [8:0] nq[$];
  bit n_stall, n_sticky, n_hv, n_err;
  bit [8:0] n_hold;
  bit e_ov, e_bd, e_ud, e_push, e_pop;
  int e_tag;

  task automatic model_eval();
    bit stall_now, quiet, ren, unb, have, pb, pf;
    bit [8:0] cur, tmp, pfe;
    n_stall = (m_stall | bb) & ~bu;
    stall_now = n_stall | rf;
    quiet = re && (infl == 0);
    n_st = m_st; nq = mq; n_sticky = m_sticky; n_hv = m_hv; n_hold = m_hold; n_err = m_err;
    e_ov = 0; e_bd = 0; e_ud = 0; e_push = 0; e_pop = 0; e_tag = 0;
    ren = 0; unb = 0; have = 0; pb = 0; pf = 0; cur = 0; pfe = 0;
    if (sq) begin
      if (m_st == S_BLK || m_st == S_UNB || m_st == S_SER) e_ud = 1;
      n_hv = 0; nq.delete(); n_st = S_SQ;
    end else if (sqb) n_st = S_SQ;
    else if (stall_now) begin
      pb = i_v;
      if (m_st != S_BLK && m_st != S_UNB) e_bd = 1;
      if (m_st != S_SER) n_st = S_BLK;
    end else begin
      if (m_st == S_BLK) begin n_st = S_UNB; ren = 1; end
      else if (m_st == S_SQ) begin n_st = S_RUN; ren = 1; end
      else if (m_st == S_SER) begin
        pb = i_v;
        if (quiet) begin pf = 1; pfe = {3'b100, m_hold[5:0]}; n_hv = 0; n_st = S_UNB; end
      end else ren = 1;
    end
    if (ren) begin
      unb = (n_st == S_UNB);
      if (unb) begin pb = i_v; have = mq.size() > 0; if (have) cur = mq[0]; end
      else begin have = i_v; cur = {1'b0, i_sb, i_sa, i_tag}; end
      if (have) begin
        if (unb) begin void'(nq.pop_front()); e_pop = 1; end
        if (m_sticky) begin n_sticky = 0; if (!quiet) cur[7] = 1; end
        if (cur[7] && !cur[8]) begin
          n_hv = 1; n_hold = cur; n_st = S_SER;
          if (m_st != S_BLK && m_st != S_UNB) e_bd = 1;
        end else begin
          e_ov = 1; e_tag = cur[5:0];
          if (cur[6] && !cur[8]) begin
            if (unb && nq.size() >= 1) begin tmp = nq[0]; tmp[7] = 1; nq[0] = tmp; end
            else n_sticky = 1;
          end
        end
      end
    end
    if (pf) begin if (nq.size() < DEPTH) nq.push_front(pfe); else n_err = 1; end
    if (pb) begin if (nq.size() < DEPTH) nq.push_back({1'b0, i_sb, i_sa, i_tag}); else n_err = 1; end
    e_push = pf | pb;
    if (ren && unb && n_st == S_UNB && nq.size() == 0) begin e_ud = 1; n_st = S_RUN; end
  endtask

  task automatic step();
    #1;
    model_eval();
    chk("R4", "state", int'(state), m_st);
    chk("R12", "out_valid", int'(out_valid), int'(e_ov));
    if (e_ov) chk("R12", "out_tag", int'(out_tag), e_tag);
    chk("R3", "up_block", int'(up_block), int'(e_bd));
    chk("R5", "up_unblock", int'(up_unblock), int'(e_ud));
    chk("R3", "skid_push", int'(skid_push), int'(e_push));
    chk("R5", "skid_pop", int'(skid_pop), int'(e_pop));
    chk("R11", "stage_active", int'(stage_active), int'(m_st == S_UNB));
    chk("R10", "skid_err", int'(skid_err), int'(m_err));
    if (out_valid) got.push_back(int'(out_tag));
    @(posedge clk);
    m_st = n_st; mq = nq; m_stall = n_stall; m_sticky = n_sticky;
    m_hv = n_hv; m_hold = n_hold; m_err = n_err;
    @(negedge clk);
    i_v = 0; i_sb = 0; i_sa = 0; sq = 0; sqb = 0; bb = 0; bu = 0; rf = 0;
  endtask

  task automatic feed(input int t, input bit sbf, input bit saf);
    i_v = 1; i_tag = 6'(t); i_sb = sbf; i_sa = saf;
    step();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int ub0, bd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "reset state", int'(state), S_IDLE);
    chk("R1", "reset outputs", int'({out_valid, up_block, up_unblock, skid_err}), 0);
    @(negedge clk);

    // R12 passthrough
    for (int t = 1; t <= 4; t++) feed(t, 0, 0);
    chk("R12", "pass order", pos(4) - pos(1), 3);

    // R3/R4/R5 block, release with concurrent input, drain
    bd0 = 0;
    bb = 1; #1; bd0 += int'(up_block); feed(5, 0, 0);
    #1; bd0 += int'(up_block); feed(6, 0, 0);
    bu = 1; feed(7, 0, 0);
    idle(4);
    chk("R3", "single block pulse", bd0, 1);
    chk("R5", "drain order", int'(pos(5) < pos(6) && pos(6) < pos(7)), 1);
    chk("R5", "running after drain", int'(state), S_RUN);

    // R3 resource full
    rf = 1; feed(8, 0, 0);
    idle(3);
    chk("R3", "full then emitted", int'(pos(8) > pos(7)), 1);

    // R2 squash-busy drops input, R4 back to running
    sqb = 1; feed(30, 0, 0);
    chk("R2", "squash-busy state", int'(state), S_SQ);
    idle(1);
    chk("R2", "busy input dropped", pos(30), -1);
    chk("R4", "squashing to running", int'(state), S_RUN);

    // R7/R8 serialize-before
    re = 0; infl = 3;
    feed(10, 1, 0);
    chk("R7", "enter serialize stall", int'(state), S_SER);
    feed(11, 0, 0); feed(12, 0, 0); idle(2);
    chk("R7", "held not emitted", pos(10), -1);
    re = 1; infl = 2; idle(1);
    chk("R7", "inflight keeps stall", int'(state), S_SER);
    infl = 0; idle(6);
    chk("R8", "held emitted", int'(pos(10) >= 0), 1);
    chk("R8", "held first", int'(pos(10) < pos(11) && pos(11) < pos(12)), 1);

    // R9 serialize-after via sticky flag
    re = 0; infl = 1;
    feed(20, 0, 1);
    feed(21, 0, 0);
    chk("R9", "successor stalls", int'(state), S_SER);
    re = 1; infl = 0; idle(4);
    chk("R9", "order after", int'(pos(21) > pos(20)), 1);
    feed(22, 0, 1);
    feed(23, 0, 0);
    chk("R9", "sticky dropped when quiet", int'(state), S_RUN);
    chk("R9", "successor emitted", int'(pos(23) > pos(22)), 1);

    // R9 serialize-after marking a buffered successor while unblocking
    re = 0; infl = 1;
    bb = 1; feed(40, 0, 1);
    feed(41, 0, 0);
    bu = 1; feed(42, 0, 0);
    idle(1);
    chk("R9", "buffered successor stalls", int'(state), S_SER);
    re = 1; infl = 0; idle(6);
    chk("R9", "buffered order", int'(pos(40) < pos(41) && pos(41) < pos(42)), 1);

    // R6 squash while blocked
    bb = 1; feed(50, 0, 0);
    feed(51, 0, 0);
    sq = 1; bu = 1; i_v = 1; i_tag = 52; #1; ub0 = int'(up_unblock); step();
    chk("R6", "unblock on squash", ub0, 1);
    idle(3);
    chk("R6", "squashed never emitted", int'(pos(50) == -1 && pos(51) == -1 && pos(52) == -1), 1);
    chk("R6", "running after squash", int'(state), S_RUN);

    // R6 squash drops held serializing instruction
    re = 0; infl = 1;
    feed(60, 1, 0);
    sq = 1; step();
    re = 1; infl = 0; idle(3);
    chk("R6", "held dropped", pos(60), -1);

    // R10 overflow
    chk("R10", "no error before", int'(skid_err), 0);
    bb = 1; feed(70, 0, 0);
    for (int t = 71; t <= 76; t++) feed(t, 0, 0);
    chk("R10", "overflow flagged", int'(skid_err), 1);
    bu = 1; idle(8);
    chk("R10", "error sticky", int'(skid_err), 1);

    done = 1;
    summary();
    $finish;
  end
endmodule